// File: doc/BRIEF.md
# Carry-Select Next-Address Incrementer

This block computes the address of the next sequential instruction from the current fetch address and two decode flags. The first flag, `has_regid`, marks an instruction that carries a register-specifier byte. The second flag, `has_const`, marks an instruction that carries a 4-byte constant word. The instruction length is 1, 2, 5 or 6 bytes, and the output is the fetch address plus that length, modulo 2^32.

Timing drives the split. The address is divided into a narrow low field of 3 bits and a wide high field of 29 bits. The wide field is incremented by one as soon as the address is known, so that work overlaps the instruction-memory read. Once the flags arrive, a short adder adds the length to the low field. The carry out of that add then steers a two-way select between the unchanged and the incremented high field. The maximum length fits in the low field, so at most one carry ever crosses into the high field.

The block is purely combinational and has no state. Widths, the length encoding and the structure of the wide incrementer are parameters.

Top module: `pc_next_csel`

## Requirements
- R1: With `has_regid`=0 and `has_const`=0, `pc_next` equals `pc_in` + 1.
- R2: With `has_regid`=1 and `has_const`=0, `pc_next` equals `pc_in` + 2.
- R3: With `has_regid`=0 and `has_const`=1, `pc_next` equals `pc_in` + 5.
- R4: With `has_regid`=1 and `has_const`=1, `pc_next` equals `pc_in` + 6.
- R5: Bits [2:0] of `pc_next` equal (`pc_in[2:0]` + length) mod 8.
- R6: Bits [31:3] of `pc_next` equal `pc_in[31:3]` when `pc_in[2:0]` + length < 8. Otherwise they equal `pc_in[31:3]` + 1 mod 2^29.
- R7: The result wraps modulo 2^32, so `pc_in` = 0xFFFFFFFF with both flags 0 gives 0x00000000.
- R8: For every `pc_in` and every flag combination, `pc_next` equals a plain 32-bit sum of `pc_in` and the length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_in | input | 32 | Current fetch address |
| has_regid | input | 1 | Instruction carries a register-specifier byte |
| has_const | input | 1 | Instruction carries a 4-byte constant word |
| pc_next | output | 32 | Address of the next sequential instruction |

## Verification
Every low-field value from 0 to 7 is crossed with all four flag combinations. This separates the low-field sums that carry into the high field from those that do not, which is the case that exercises the select.

These 32 low/flag cases are repeated over several high-field patterns:
- zero;
- all ones, which exercises the wrap;
- long runs of ones, which test the ripple through the wide incrementer;
- alternating bits.

A pseudo-random sweep then compares the output against a plain 32-bit adder for general addresses.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;
   // Byte counts that make up an instruction length
   localparam int unsigned BASE_BYTES  = 1;
   localparam int unsigned REGID_BYTES = 1;
   localparam int unsigned CONST_BYTES = 4;
   localparam int unsigned MAX_BYTES   = BASE_BYTES + REGID_BYTES + CONST_BYTES;

   typedef enum logic [1:0] {
      FMT_BARE   = 2'b00,
      FMT_REG    = 2'b01,
      FMT_CONST  = 2'b10,
      FMT_FULL   = 2'b11
   } insn_fmt_e;

   function automatic int unsigned fmt_bytes(input insn_fmt_e f);
      int unsigned n;
      n = BASE_BYTES;
      if (f[0]) n = n + REGID_BYTES;
      if (f[1]) n = n + CONST_BYTES;
      return n;
   endfunction
endpackage

// File: rtl/pc_len_encode.sv
module pc_len_encode
   import pc_next_pkg::*;
#(
   parameter int unsigned LOW_W = 3
) (
   input  logic             has_regid,
   input  logic             has_const,
   output logic [LOW_W-1:0] len
);
   insn_fmt_e fmt;

   always_comb begin
      fmt = insn_fmt_e'({has_const, has_regid});
      len = LOW_W'(fmt_bytes(fmt));
   end
endmodule

// File: rtl/pc_low_adder.sv
module pc_low_adder #(
   parameter int unsigned LOW_W = 3
) (
   input  logic [LOW_W-1:0] low_in,
   input  logic [LOW_W-1:0] len,
   output logic [LOW_W-1:0] low_sum,
   output logic             carry
);
   always_comb begin
      {carry, low_sum} = {1'b0, low_in} + {1'b0, len};
   end
endmodule

// File: rtl/pc_high_incr.sv
module pc_high_incr #(
   parameter int unsigned HIGH_W    = 29,
   parameter int unsigned INC_STYLE = 1   // 0: behavioural adder, 1: explicit ripple chain
) (
   input  logic [HIGH_W-1:0] hi_in,
   output logic [HIGH_W-1:0] hi_inc
);
   generate
      if (INC_STYLE == 0) begin : g_behav
         assign hi_inc = hi_in + HIGH_W'(1);
      end else begin : g_ripple
         logic [HIGH_W:0] cy;
         assign cy[0] = 1'b1;
         for (genvar i = 0; i < HIGH_W; i++) begin : g_bit
            assign hi_inc[i] = hi_in[i] ^ cy[i];
            assign cy[i+1]   = hi_in[i] & cy[i];
         end
      end
   endgenerate
endmodule

// File: rtl/pc_carry_mux.sv
module pc_carry_mux #(
   parameter int unsigned HIGH_W = 29
) (
   input  logic              sel,
   input  logic [HIGH_W-1:0] hi_keep,
   input  logic [HIGH_W-1:0] hi_bump,
   output logic [HIGH_W-1:0] hi_out
);
   always_comb begin
      hi_out = sel ? hi_bump : hi_keep;
   end
endmodule

// File: rtl/pc_next_csel.sv
module pc_next_csel
   import pc_next_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LOW_W     = 3,
   parameter int unsigned INC_STYLE = 1
) (
   input  logic [ADDR_W-1:0] pc_in,
   input  logic              has_regid,
   input  logic              has_const,
   output logic [ADDR_W-1:0] pc_next
);
   localparam int unsigned HIGH_W = ADDR_W - LOW_W;

   // Elaboration-time parameter checks
   generate
      if (LOW_W < 1 || LOW_W >= ADDR_W) begin : g_bad_split
         $error("pc_next_csel: LOW_W must lie in 1..ADDR_W-1");
      end
      if (MAX_BYTES >= (1 << LOW_W)) begin : g_bad_low
         $error("pc_next_csel: longest instruction must fit in the low field");
      end
      if (INC_STYLE > 1) begin : g_bad_style
         $error("pc_next_csel: INC_STYLE must be 0 or 1");
      end
   endgenerate

   logic [LOW_W-1:0]  len;
   logic [LOW_W-1:0]  low_sum;
   logic              low_carry;
   logic [HIGH_W-1:0] hi_inc;
   logic [HIGH_W-1:0] hi_sel;

   pc_len_encode #(.LOW_W(LOW_W)) u_len (
      .has_regid (has_regid),
      .has_const (has_const),
      .len       (len)
   );

   // Wide increment depends on the address alone
   pc_high_incr #(.HIGH_W(HIGH_W), .INC_STYLE(INC_STYLE)) u_hinc (
      .hi_in  (pc_in[ADDR_W-1:LOW_W]),
      .hi_inc (hi_inc)
   );

   pc_low_adder #(.LOW_W(LOW_W)) u_ladd (
      .low_in  (pc_in[LOW_W-1:0]),
      .len     (len),
      .low_sum (low_sum),
      .carry   (low_carry)
   );

   pc_carry_mux #(.HIGH_W(HIGH_W)) u_mux (
      .sel     (low_carry),
      .hi_keep (pc_in[ADDR_W-1:LOW_W]),
      .hi_bump (hi_inc),
      .hi_out  (hi_sel)
   );

   assign pc_next = {hi_sel, low_sum};
endmodule

// File: rtl/pc_next_csel_chk.sv
module pc_next_csel_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LOW_W  = 3
) (
   input logic [ADDR_W-1:0] pc_in,
   input logic              has_regid,
   input logic              has_const,
   input logic [ADDR_W-1:0] pc_next
);
   localparam int unsigned HIGH_W = ADDR_W - LOW_W;

   logic [ADDR_W-1:0] nbytes;
   logic [LOW_W:0]    low_wide;
   logic [HIGH_W-1:0] hi_diff;

   always_comb begin
      nbytes   = ADDR_W'(1) + (has_regid ? ADDR_W'(1) : '0) + (has_const ? ADDR_W'(4) : '0);
      low_wide = {1'b0, pc_in[LOW_W-1:0]} + (LOW_W+1)'(nbytes);
      hi_diff  = pc_next[ADDR_W-1:LOW_W] - pc_in[ADDR_W-1:LOW_W];
      if (!$isunknown({pc_in, has_regid, has_const, pc_next})) begin
         if (!has_regid && !has_const)
            assert_len_one_R1: assert (pc_next - pc_in == ADDR_W'(1)) else $error("R1 violated");
         if (has_regid && !has_const)
            assert_len_two_R2: assert (pc_next - pc_in == ADDR_W'(2)) else $error("R2 violated");
         if (!has_regid && has_const)
            assert_len_five_R3: assert (pc_next - pc_in == ADDR_W'(5)) else $error("R3 violated");
         if (has_regid && has_const)
            assert_len_six_R4: assert (pc_next - pc_in == ADDR_W'(6)) else $error("R4 violated");
         assert_low_field_R5: assert (pc_next[LOW_W-1:0] == low_wide[LOW_W-1:0]) else $error("R5 violated");
         assert_high_select_R6: assert (hi_diff == HIGH_W'(low_wide[LOW_W])) else $error("R6 violated");
         if (&pc_in && !has_regid && !has_const)
            assert_wrap_R7: assert (pc_next == '0) else $error("R7 violated");
         assert_sum_match_R8: assert (pc_next == pc_in + nbytes) else $error("R8 violated");
      end
   end
endmodule

bind pc_next_csel pc_next_csel_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
   .pc_in     (pc_in),
   .has_regid (has_regid),
   .has_const (has_const),
   .pc_next   (pc_next)
);

// File: tb/pc_next_csel_tb.sv
module pc_next_csel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_in = '0;
   logic        has_regid = 1'b0;
   logic        has_const = 1'b0;
   logic [31:0] pc_next;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   pc_next_csel u_dut (
      .pc_in     (pc_in),
      .has_regid (has_regid),
      .has_const (has_const),
      .pc_next   (pc_next)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s pc=%08h r=%0b c=%0b actual=%08h expected=%08h",
                  req, pc_in, has_regid, has_const, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] pc, input logic r, input logic c);
      logic [31:0] len;
      logic [31:0] exp;
      logic [3:0]  lsum;
      logic [28:0] hexp;
      @(negedge clk);
      pc_in = pc; has_regid = r; has_const = c;
      #1;
      len  = 32'd1 + (r ? 32'd1 : 32'd0) + (c ? 32'd4 : 32'd0);
      exp  = pc + len;
      lsum = {1'b0, pc[2:0]} + len[3:0];
      hexp = lsum[3] ? pc[31:3] + 29'd1 : pc[31:3];
      case ({c, r})
         2'b00: check("R1", pc_next, exp);
         2'b01: check("R2", pc_next, exp);
         2'b10: check("R3", pc_next, exp);
         default: check("R4", pc_next, exp);
      endcase
      check("R5", {29'd0, pc_next[2:0]}, {29'd0, lsum[2:0]});
      check("R6", {3'd0, pc_next[31:3]}, {3'd0, hexp});
      check("R8", pc_next, exp);
      if (pc == 32'hFFFF_FFFF && !r && !c) check("R7", pc_next, 32'h0);
   endtask

   logic [28:0] hi_pat [8];

   initial begin
      logic [31:0] lfsr;
      hi_pat[0] = 29'h0;          hi_pat[1] = 29'h1FFF_FFFF;
      hi_pat[2] = 29'h0FFF_FFFF;  hi_pat[3] = 29'h0000_FFFF;
      hi_pat[4] = 29'h1555_5555;  hi_pat[5] = 29'h0AAA_AAAA;
      hi_pat[6] = 29'h0000_0001;  hi_pat[7] = 29'h1000_0000;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Idle input state after reset: zero address, bare format gives 1 (R1)
      @(negedge clk); #1;
      check("R1", pc_next, 32'h1);
      for (int h = 0; h < 8; h++)
         for (int lo = 0; lo < 8; lo++)
            for (int f = 0; f < 4; f++)
               apply({hi_pat[h], 3'(lo)}, f[0], f[1]);
      // Wrap corners (R7)
      apply(32'hFFFF_FFFF, 1'b0, 1'b0);
      apply(32'hFFFF_FFFA, 1'b1, 1'b1);
      lfsr = 32'hACE1_1234;
      for (int k = 0; k < 2000; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         apply(lfsr, lfsr[5], lfsr[9]);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule